// File: doc/BRIEF.md
# Round-Robin TDC Word Multiplexer

This block collects 32-bit hit words from a row of time-to-digital converter input queues and turns them into a single byte stream for a serial link that uses 8B/10B line coding. Its work is split into readout cycles. Every cycle opens with one control character. The inputs then follow in ascending index order, and each input gets exactly one word slot of four bytes. If an input has a word waiting, that word goes into its slot. If it has none, the slot carries a placeholder word that names the input. The receiver can therefore rebuild the position of every word from the slot count alone.

Each input offers a standard valid/ready interface. A word leaves its queue only after the link has accepted its final byte. The output presents a byte, a control flag that separates the control character from data, and a valid/ready handshake, so the downstream encoder can hold the stream back at any byte.

Top module: `tdc_slot_mux`

## Requirements
- R1: While reset is held, out_valid and every in_ready bit are 0. The first byte presented after reset is the control character 0xBC with out_ctrl = 1.
- R2: Every cycle consists of one control byte (0xBC, out_ctrl = 1) followed by exactly N_IN × 4 data bytes with out_ctrl = 0. The data bytes carry slots 0, 1, … N_IN−1 in that order, four bytes per slot.
- R3: When an input's word is taken into its slot, the four bytes are the word's bits [31:24], [23:16], [15:8] and [7:0], in that order.
- R4: When an input has no word, its slot carries 0xF0000000 plus the input index. That is, bits [31:28] = 0xF, bits [4:0] = index, and all other bits are 0.
- R5: The choice between word and placeholder is made on the clock edge where the slot becomes current. A word that arrives after that edge is not used and not consumed in this slot. It is sent in the same input's slot in the next cycle.
- R6: in_ready[i] is high only in the cycle where the last byte of slot i is accepted (out_valid and out_ready both high) and that slot carries input i's word. At most one in_ready bit is high at a time.
- R7: While out_valid is high and out_ready is low, out_byte and out_ctrl hold their values and out_valid stays high.
- R8: Every word offered on an input is sent exactly once and removed from its queue exactly once. Words from one input leave in the order they were offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Per-input word available |
| in_data | input | N_IN×WORD_W | Per-input word, input i at bits [i×WORD_W +: WORD_W] |
| in_ready | output | N_IN | Per-input word consumed on this edge |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Link accepts the byte on this edge |
| out_byte | output | 8 | Data byte or control character |
| out_ctrl | output | 1 | 1 marks a control character |

## Verification
The slot decision for an input can coincide with that input's word arriving, and the removal of a word can coincide with a link stall. The bench pushes words into input 0, input 5 and input 17 just after their slots have started. It expects a placeholder in the current cycle and the real word one cycle later. The link ready line is toggled in irregular and regular patterns so that stalls land on last bytes; the expectation is that in_ready waits for the real acceptance of the last byte. A scoreboard derives each expected byte and ready pulse from the slot position and from the input state the bench drove at the deciding edge.

// File: rtl/tdcmux_pkg.sv
package tdcmux_pkg;
   localparam logic [7:0] K_TOKEN   = 8'hBC;
   localparam logic [3:0] PH_TAG    = 4'hF;
   localparam int         PH_IDX_W  = 5;
   localparam int         LANE_W    = 8;
endpackage

// File: rtl/tdcmux_seq.sv
module tdcmux_seq #(
   parameter int N_IN  = 18,
   parameter int BYTES = 4,
   localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
   localparam int BIDX_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              out_ready,
   output logic              running,
   output logic              is_tok,
   output logic [IDX_W-1:0]  slot,
   output logic [BIDX_W-1:0] bidx,
   output logic              adv,
   output logic              slot_last,
   output logic              enter_slot,
   output logic [IDX_W-1:0]  enter_idx
);
   localparam logic [IDX_W-1:0]  LAST_SLOT = IDX_W'(N_IN - 1);
   localparam logic [BIDX_W-1:0] LAST_B    = BIDX_W'(BYTES - 1);

   always_comb begin
      adv        = running & out_ready;
      slot_last  = !is_tok && (bidx == LAST_B);
      enter_slot = adv && (is_tok || (slot_last && slot != LAST_SLOT));
      enter_idx  = is_tok ? '0 : IDX_W'(slot + 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         is_tok  <= 1'b1;
         slot    <= '0;
         bidx    <= '0;
      end else begin
         running <= 1'b1;
         if (adv) begin
            if (is_tok) begin
               is_tok <= 1'b0;
               slot   <= '0;
               bidx   <= '0;
            end else if (bidx == LAST_B) begin
               bidx <= '0;
               if (slot == LAST_SLOT) is_tok <= 1'b1;
               else                   slot   <= IDX_W'(slot + 1'b1);
            end else begin
               bidx <= BIDX_W'(bidx + 1'b1);
            end
         end
      end
   end
endmodule

// File: rtl/tdcmux_slot_src.sv
module tdcmux_slot_src
   import tdcmux_pkg::*;
#(
   parameter int N_IN   = 18,
   parameter int WORD_W = 32,
   localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN-1:0]        in_valid,
   input  logic [N_IN*WORD_W-1:0] in_data,
   input  logic [IDX_W-1:0]       slot,
   input  logic                   enter_slot,
   input  logic [IDX_W-1:0]       enter_idx,
   input  logic                   adv,
   input  logic                   slot_last,
   output logic [WORD_W-1:0]      word,
   output logic [N_IN-1:0]        in_ready
);
   logic              take_q;
   logic [WORD_W-1:0] ph_word;

   always_ff @(posedge clk) begin
      if (!rst_n)          take_q <= 1'b0;
      else if (enter_slot) take_q <= in_valid[enter_idx];
   end

   always_comb begin
      ph_word                      = '0;
      ph_word[WORD_W-1 -: 4]       = PH_TAG;
      ph_word[PH_IDX_W-1:0]        = PH_IDX_W'(slot);
      word = take_q ? in_data[int'(slot)*WORD_W +: WORD_W] : ph_word;
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_pop
      assign in_ready[i] = adv && slot_last && take_q && (slot == IDX_W'(i));
   end
endmodule

// File: rtl/tdc_slot_mux.sv
module tdc_slot_mux
   import tdcmux_pkg::*;
#(
   parameter int N_IN   = 18,
   parameter int WORD_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN-1:0]        in_valid,
   input  logic [N_IN*WORD_W-1:0] in_data,
   output logic [N_IN-1:0]        in_ready,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [7:0]             out_byte,
   output logic                   out_ctrl
);
   localparam int BYTES  = WORD_W / LANE_W;
   localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1;
   localparam int BIDX_W = $clog2(BYTES);

   if (N_IN < 1 || N_IN > (1 << PH_IDX_W)) begin : g_bad_n
      $error("N_IN must lie in 1..32 so the placeholder index fits");
   end
   if (WORD_W % LANE_W != 0 || BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_w
      $error("WORD_W must be a power-of-two count of bytes, at least two");
   end

   logic              running, is_tok, adv, slot_last, enter_slot;
   logic [IDX_W-1:0]  slot, enter_idx;
   logic [BIDX_W-1:0] bidx;
   logic [WORD_W-1:0] word;
   logic [7:0]        lane [BYTES];

   tdcmux_seq #(.N_IN(N_IN), .BYTES(BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .out_ready(out_ready),
      .running(running), .is_tok(is_tok), .slot(slot), .bidx(bidx),
      .adv(adv), .slot_last(slot_last),
      .enter_slot(enter_slot), .enter_idx(enter_idx)
   );

   tdcmux_slot_src #(.N_IN(N_IN), .WORD_W(WORD_W)) u_src (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .slot(slot), .enter_slot(enter_slot), .enter_idx(enter_idx),
      .adv(adv), .slot_last(slot_last), .word(word), .in_ready(in_ready)
   );

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign lane[b] = word[WORD_W-1-LANE_W*b -: LANE_W];
   end

   assign out_valid = running;
   assign out_ctrl  = is_tok;
   assign out_byte  = is_tok ? K_TOKEN : lane[bidx];
endmodule

// File: rtl/tdcmux_chk.sv
module tdcmux_chk #(
   parameter int N_IN  = 18,
   parameter int BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_IN-1:0] in_valid,
   input logic [N_IN-1:0] in_ready,
   input logic            out_valid,
   input logic            out_ready,
   input logic [7:0]      out_byte,
   input logic            out_ctrl
);
   localparam int TOTAL = N_IN * BYTES;
   localparam int CNT_W = $clog2(TOTAL + 1) + 1;

   logic             seen_tok;
   logic [CNT_W-1:0] data_cnt;
   logic             hs;

   assign hs = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_tok <= 1'b0;
         data_cnt <= '0;
      end else if (hs) begin
         if (out_ctrl) begin
            seen_tok <= 1'b1;
            data_cnt <= '0;
         end else begin
            data_cnt <= CNT_W'(data_cnt + 1'b1);
         end
      end
   end

   a_r1_first_is_token: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_ctrl && out_byte == 8'hBC));

   a_r2_token_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && out_ctrl && seen_tok) |-> (data_cnt == CNT_W'(TOTAL)));

   a_r2_no_extra_data: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && !out_ctrl) |-> (seen_tok && data_cnt < CNT_W'(TOTAL)));

   a_r2_token_code: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl) |-> (out_byte == 8'hBC));

   a_r6_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));

   a_r6_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (|in_ready) |-> (hs && !out_ctrl && (in_ready & ~in_valid) == '0));

   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_ctrl)));
endmodule

bind tdc_slot_mux tdcmux_chk #(.N_IN(N_IN), .BYTES(WORD_W / 8)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready),
   .out_byte(out_byte), .out_ctrl(out_ctrl)
);

// File: tb/tdc_slot_mux_bench.sv
module tdc_slot_mux_bench;
   localparam int N = 18;
   localparam int W = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   in_valid = '0;
   logic [N*W-1:0] in_data = '0;
   logic [N-1:0]   in_ready;
   logic           out_valid, out_ready = 1'b1, out_ctrl;
   logic [7:0]     out_byte;

   tdc_slot_mux #(.N_IN(N), .WORD_W(W)) u_tdc_slot_mux (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
      .out_byte(out_byte), .out_ctrl(out_ctrl)
   );

   always #5 clk = ~clk;

   logic [31:0] q [N][$];
   int n_cmp = 0, n_bad = 0, pushed = 0, popped = 0, cycles = 0;
   int rdy_mode = 0;
   bit done = 0;
   logic [N-1:0] pend_pop = '0;
   bit late [N];

   // scoreboard model state
   bit          m_tok = 1;
   int          m_slot = 0, m_byte = 0;
   bit          m_take = 0;
   logic [31:0] m_word = '0;
   bit          prev_stall = 0;
   logic [7:0]  prev_byte;
   bit          prev_ctrl;
   bit          reset_checked = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic void decide(input int s);
      m_take = in_valid[s];
      m_word = m_take ? in_data[s*W +: W] : {4'hF, 23'd0, 5'(s)};
   endfunction

   // monitor: compares at the negedge, before the edge that completes the handshake
   always @(negedge clk) begin
      if (!rst_n) begin
         if (!reset_checked) begin
            chk(out_valid == 1'b0 && in_ready == '0, "R1 reset quiet",
                {in_ready, 13'd0, out_valid}, 32'd0);
            reset_checked = 1;
         end
      end else begin
         logic [N-1:0] er;
         bit hs;
         hs = out_valid && out_ready;
         if (prev_stall)
            chk(out_valid && out_byte == prev_byte && out_ctrl == prev_ctrl, "R7 stall hold",
                {23'd0, out_valid, out_ctrl, out_byte}, {24'd1, prev_ctrl, prev_byte} >> 0);
         er = '0;
         if (hs && !m_tok && m_byte == 3 && m_take) er[m_slot] = 1'b1;
         chk(in_ready == er, "R6 ready pulse", 32'(in_ready), 32'(er));
         if (hs) begin
            if (m_tok) begin
               chk(out_ctrl == 1'b1 && out_byte == 8'hBC, "R1/R2 token",
                   {23'd0, out_ctrl, out_byte}, {23'd0, 1'b1, 8'hBC});
               m_tok = 0; m_slot = 0; m_byte = 0;
               decide(0);
            end else begin
               logic [7:0] eb;
               string tag;
               eb  = m_word[31-8*m_byte -: 8];
               tag = late[m_slot] ? "R5 late word deferred" : (m_take ? "R3 word bytes" : "R4 placeholder");
               chk(out_ctrl == 1'b0 && out_byte == eb, tag,
                   {23'd0, out_ctrl, out_byte}, {24'd0, eb});
               if (m_byte == 3) begin
                  if (m_take) pend_pop[m_slot] = 1'b1;
                  late[m_slot] = 0;
                  m_byte = 0;
                  if (m_slot == N-1) m_tok = 1;
                  else begin
                     m_slot++;
                     decide(m_slot);
                  end
               end else m_byte++;
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_byte  = out_byte;
         prev_ctrl  = out_ctrl;
      end
   end

   // driver: applies pops, drives queue heads and link ready after each edge
   always @(posedge clk) begin
      #1;
      cycles++;
      for (int i = 0; i < N; i++) begin
         if (pend_pop[i]) begin
            void'(q[i].pop_front());
            popped++;
         end
      end
      pend_pop = '0;
      for (int i = 0; i < N; i++) begin
         in_valid[i] = (q[i].size() > 0);
         in_data[i*W +: W] = (q[i].size() > 0) ? q[i][0] : 32'hDEAD_0000;
      end
      case (rdy_mode)
         0: out_ready = 1'b1;
         1: out_ready = ($urandom % 4) != 0;
         default: out_ready = (cycles % 3) != 0;
      endcase
      if (cycles > 150000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic push(input int i, input logic [31:0] w);
      q[i].push_back(w);
      pushed++;
   endtask

   task automatic wait_drain();
      bit busy;
      do begin
         @(negedge clk);
         busy = 0;
         for (int i = 0; i < N; i++) if (q[i].size() > 0) busy = 1;
      end while (busy);
      repeat (160) @(negedge clk);
   endtask

   task automatic late_push(input int k, input logic [31:0] w);
      do @(negedge clk); while (!(!m_tok && m_slot == k && m_byte == 1));
      late[k] = 1;
      push(k, w);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // idle cycles: placeholders everywhere (R2, R4)
      repeat (160) @(negedge clk);
      // one word per input, several on edge inputs (R3, R8)
      for (int i = 0; i < N; i++) push(i, 32'h1000_0000 | (i << 8) | 1);
      for (int j = 2; j < 5; j++) begin
         push(0, 32'hA000_0000 | j);
         push(17, 32'hB700_0000 | j);
         push(9, 32'hC900_0000 | j);
      end
      wait_drain();
      // irregular link stalls (R6, R7)
      rdy_mode = 1;
      for (int i = 0; i < N; i += 2) push(i, 32'h2200_0000 | (i << 16) | 32'h55);
      push(3, 32'h0123_4567);
      push(3, 32'h89AB_CDEF);
      wait_drain();
      // words arriving after their slot started (R5)
      late_push(5, 32'h5A5A_0005);
      wait_drain();
      late_push(0, 32'h5A5A_0000);
      wait_drain();
      late_push(17, 32'h5A5A_0011);
      wait_drain();
      // regular stall pattern, lands on last bytes (R6, R7)
      rdy_mode = 2;
      for (int i = 0; i < N; i++) push(i, 32'h3300_0000 | i);
      push(17, 32'hFFFF_FFFF);
      wait_drain();
      // every offered word left its queue exactly once (R8)
      begin
         bit empty;
         empty = 1;
         for (int i = 0; i < N; i++) if (q[i].size() > 0) empty = 0;
         chk(empty && pushed == popped, "R8 exactly once", popped, pushed);
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule